// File: doc/BRIEF.md
# Continuous-Phase Binary FSK Tone Generator

This block is the waveform source of a low-speed modem transmitter. On every sample tick it emits one 8-bit unsigned sample of a sine wave. A PWM stage or a small DAC turns these samples into audio. The frequency is set by direct digital synthesis. A 16-bit phase register advances on each tick by a fixed step, and the top six bits of that register select one of 64 stored sine values.

Two inputs choose the step. A channel select input picks the low frequency pair or the high frequency pair. The data bit picks the upper (mark) or lower (space) tone of that pair. The phase register is never cleared when the step changes, and it wraps on overflow with no extra logic. A change of data or channel therefore bends the frequency without a jump in phase. The sample tick is expected at about 31.25 kHz. The block itself only counts ticks and needs no knowledge of the rate.

Top module: `fsk_tone_gen`

## Requirements
- R1: While rst_ni is low, sample_o reads 128 and the phase is 0, so the first tick after reset also yields 128.
- R2: On clock edges where tick_i is low, sample_o and the phase hold their values.
- R3: With answer_i = 0, each tick adds 2244 to the phase when data_i = 0 and 2663 when data_i = 1.
- R4: With answer_i = 1, each tick adds 4247 to the phase when data_i = 0 and 4666 when data_i = 1.
- R5: The sample registered on a tick is the table entry for the phase held before that tick's step is added.
- R6: The phase is 16 bits unsigned and wraps modulo 65536 with no correction.
- R7: The table entry k (0..63) is round(128 + 127*sin(2*pi*k/64)), addressed by phase bits 15..10. It is 128 at k = 0 and k = 32, 255 at k = 16, and 1 at k = 48.
- R8: A change of data_i or answer_i is used only on the next tick and never resets the phase, so the phase sequence stays continuous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle sample strobe |
| answer_i | input | 1 | 0: low tone pair, 1: high tone pair |
| data_i | input | 1 | 0: space tone, 1: mark tone |
| sample_o | output | 8 | Registered unsigned sine sample |

## Verification
Each of the four steps is run alone for long enough that the phase wraps several times. A wrong step constant or a broken wrap shows up as a sample mismatch within a few ticks. Runs where the data bit toggles on every tick, or where the channel flips mid-run, separate a continuous-phase design from one that clears or reloads the phase. Changing the inputs with no tick present shows whether the output or the phase moves off the strobe. The first samples after reset and the comparisons at table indices 0, 16, 32 and 48 separate the one-tick lag from reading the phase after its step.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;
  localparam int unsigned LUT_AW  = 6;
  localparam int unsigned LUT_N   = 1 << LUT_AW;
  localparam int unsigned QTR_N   = LUT_N / 4;
  localparam int unsigned SMP_W   = 8;
  localparam int unsigned MID_VAL = 128;

  typedef logic [SMP_W-1:0]  sample_t;
  typedef logic [LUT_AW-1:0] lut_addr_t;

  typedef enum logic [1:0] {
    TONE_ORIG_SPACE = 2'b00,
    TONE_ORIG_MARK  = 2'b01,
    TONE_ANS_SPACE  = 2'b10,
    TONE_ANS_MARK   = 2'b11
  } tone_e;

  // Offset from mid-scale over the first quarter wave, index 0..QTR_N
  function automatic int unsigned quarter_ofs(int unsigned k);
    case (k)
      0:  return 0;    1:  return 12;   2:  return 25;   3:  return 37;
      4:  return 49;   5:  return 60;   6:  return 71;   7:  return 81;
      8:  return 90;   9:  return 98;   10: return 106;  11: return 112;
      12: return 117;  13: return 122;  14: return 125;  15: return 126;
      default: return 127;
    endcase
  endfunction

  function automatic sample_t sine_at(int unsigned idx);
    int unsigned i;
    int unsigned v;
    i = idx % LUT_N;
    if (i <= QTR_N)            v = MID_VAL + quarter_ofs(i);
    else if (i < 2*QTR_N)      v = MID_VAL + quarter_ofs(2*QTR_N - i);
    else if (i <= 3*QTR_N)     v = MID_VAL - quarter_ofs(i - 2*QTR_N);
    else                       v = MID_VAL - quarter_ofs(LUT_N - i);
    return sample_t'(v);
  endfunction
endpackage

// File: rtl/fsk_step_sel.sv
module fsk_step_sel
  import fsk_tone_pkg::*;
#(
  parameter int unsigned PHASE_W   = 16,
  parameter int unsigned ORIG_SPACE = 2244,
  parameter int unsigned ORIG_MARK  = 2663,
  parameter int unsigned ANS_SPACE  = 4247,
  parameter int unsigned ANS_MARK   = 4666
) (
  input  logic               answer_i,
  input  logic               data_i,
  output logic [PHASE_W-1:0] step_o
);
  tone_e tone;
  assign tone = tone_e'({answer_i, data_i});

  always_comb begin
    unique case (tone)
      TONE_ORIG_SPACE: step_o = PHASE_W'(ORIG_SPACE);
      TONE_ORIG_MARK:  step_o = PHASE_W'(ORIG_MARK);
      TONE_ANS_SPACE:  step_o = PHASE_W'(ANS_SPACE);
      default:         step_o = PHASE_W'(ANS_MARK);
    endcase
  end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] phase_o
);
  // Modulo 2^PHASE_W wrap comes from the adder width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_o <= '0;
    else if (tick_i) phase_o <= phase_o + step_i;
  end
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
  import fsk_tone_pkg::*;
(
  input  lut_addr_t addr_i,
  output sample_t   data_o
);
  sample_t table_q [LUT_N];

  for (genvar k = 0; k < LUT_N; k++) begin : g_entry
    assign table_q[k] = sine_at(k);
  end

  assign data_o = table_q[addr_i];
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_tone_pkg::*;
#(
  parameter int unsigned PHASE_W    = 16,
  parameter int unsigned ORIG_SPACE = 2244,
  parameter int unsigned ORIG_MARK  = 2663,
  parameter int unsigned ANS_SPACE  = 4247,
  parameter int unsigned ANS_MARK   = 4666
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             answer_i,
  input  logic             data_i,
  output logic [SMP_W-1:0] sample_o
);
  localparam int unsigned ADDR_LSB = PHASE_W - LUT_AW;

  logic [PHASE_W-1:0] step;
  logic [PHASE_W-1:0] phase_q;
  lut_addr_t          lut_addr;
  sample_t            lut_data;

  fsk_step_sel #(
    .PHASE_W(PHASE_W), .ORIG_SPACE(ORIG_SPACE), .ORIG_MARK(ORIG_MARK),
    .ANS_SPACE(ANS_SPACE), .ANS_MARK(ANS_MARK)
  ) u_step (
    .answer_i(answer_i), .data_i(data_i), .step_o(step)
  );

  fsk_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .step_i(step), .phase_o(phase_q)
  );

  assign lut_addr = phase_q[PHASE_W-1:ADDR_LSB];

  fsk_sine_lut u_lut (.addr_i(lut_addr), .data_o(lut_data));

  // Table is read with the pre-step phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_o <= sine_at(0);
    else if (tick_i) sample_o <= lut_data;
  end
endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
  parameter int unsigned PHASE_W    = 16,
  parameter int unsigned ORIG_SPACE = 2244,
  parameter int unsigned ORIG_MARK  = 2663,
  parameter int unsigned ANS_SPACE  = 4247,
  parameter int unsigned ANS_MARK   = 4666
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               answer_i,
  input logic               data_i,
  input logic [7:0]         sample_o,
  input logic [PHASE_W-1:0] phase_q
);
  localparam int unsigned TOP = PHASE_W - 6;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(sample_o) && $stable(phase_q)));

  p_orig_space_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !answer_i && !data_i) |=> phase_q == PHASE_W'($past(phase_q) + ORIG_SPACE));

  p_orig_mark_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !answer_i && data_i) |=> phase_q == PHASE_W'($past(phase_q) + ORIG_MARK));

  p_ans_space_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && answer_i && !data_i) |=> phase_q == PHASE_W'($past(phase_q) + ANS_SPACE));

  p_ans_mark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && answer_i && data_i) |=> phase_q == PHASE_W'($past(phase_q) + ANS_MARK));

  p_peak_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_q[PHASE_W-1:TOP] == 6'd16) |=> sample_o == 8'd255);

  p_trough_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_q[PHASE_W-1:TOP] == 6'd48) |=> sample_o == 8'd1);

  p_zero_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_q[PHASE_W-1:TOP] == 6'd0) |=> sample_o == 8'd128);

  p_never_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != 8'd0);
endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(
  .PHASE_W(PHASE_W), .ORIG_SPACE(ORIG_SPACE), .ORIG_MARK(ORIG_MARK),
  .ANS_SPACE(ANS_SPACE), .ANS_MARK(ANS_MARK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .answer_i(answer_i),
  .data_i(data_i), .sample_o(sample_o), .phase_q(phase_q)
);

// File: tb/fsk_tone_gen_test.sv
`timescale 1ns/1ps
module fsk_tone_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       answer_i = 1'b0;
  logic       data_i = 1'b0;
  logic [7:0] sample_o;

  int n_chk = 0;
  int n_bad = 0;
  int ref_tbl [64];
  int unsigned ref_ph = 0;

  fsk_tone_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .answer_i(answer_i), .data_i(data_i), .sample_o(sample_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic int unsigned step_of(logic ans, logic dat);
    if (!ans) return dat ? 2663 : 2244;
    return dat ? 4666 : 4247;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: sample_o=%0d expected %0d", req, act, exp);
    end
  endtask

  // One tick, then compare against the model (pre-step phase, R5)
  task automatic one_tick(string req);
    int unsigned idx;
    int unsigned nxt;
    string tag;
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    idx = ref_ph >> 10;
    nxt = ref_ph + step_of(answer_i, data_i);
    tag = req;
    if (nxt > 65535) tag = {req, "/R6"};
    if (idx % 16 == 0) tag = {tag, "/R7"};
    check(tag, int'(sample_o), ref_tbl[idx]);
    ref_ph = nxt & 16'hFFFF;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 in reset", int'(sample_o), 128);
    rst_ni = 1'b1;
    ref_ph = 0;
    @(negedge clk_i);
    check("R1 after release", int'(sample_o), 128);
    answer_i = 1'b0; data_i = 1'b1;
    one_tick("R1 first tick R5");
    one_tick("R5 second tick");
  endtask

  task automatic t_hold;
    logic [7:0] seen;
    seen = sample_o;
    answer_i = 1'b1; data_i = 1'b0;
    repeat (5) @(negedge clk_i);
    data_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R2 hold without tick", int'(sample_o), int'(seen));
    // phase untouched: next tick must follow the model
    one_tick("R2 R8 phase kept");
  endtask

  task automatic t_run(logic ans, logic dat, int n, string req);
    answer_i = ans; data_i = dat;
    for (int i = 0; i < n; i++) one_tick(req);
  endtask

  task automatic t_toggle_data;
    answer_i = 1'b0;
    for (int i = 0; i < 60; i++) begin
      data_i = i[0];
      one_tick("R8 data toggle");
    end
  endtask

  task automatic t_toggle_mode;
    for (int i = 0; i < 60; i++) begin
      answer_i = i[1];
      data_i = i[2];
      one_tick("R8 mode change");
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++)
      ref_tbl[k] = int'($floor(128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * k / 64.0) + 0.5));
    t_reset();
    t_hold();
    t_run(1'b0, 1'b0, 90, "R3 space");
    t_run(1'b0, 1'b1, 90, "R3 mark");
    t_run(1'b1, 1'b0, 90, "R4 space");
    t_run(1'b1, 1'b1, 90, "R4 mark");
    t_toggle_data();
    t_toggle_mode();
    t_run(1'b0, 1'b0, 300, "R7 table sweep");
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule